// File: doc/BRIEF.md
# Registered bidirectional bus transceiver

This block links two 8-bit buses, A and B, through a bidirectional transceiver that holds a storage register for each direction. The A-side register samples the A bus on each rising edge of its own clock. The B-side register samples the B bus on each rising edge of a second, independent clock. Capture never depends on the enable or the direction inputs, so data can be stored while both ports are isolated.

An active-low enable and a direction input choose which port, if any, is driven. For the driven port, a select input picks one of two sources. The first is the live value on the opposite bus, which is the transparent path. The second is that bus's stored register, which is the stored path. The output paths are purely combinational, so a value captured in stored mode appears on the driven port just after the capturing edge.

Each pad is modelled as a separate input, output and output-enable vector, which keeps the block synthesizable. A parameter makes every driven value bitwise inverted, while the registers keep holding the true data. An active-low asynchronous reset clears both registers.

Top module: `xcvr_reg_bus`

## Requirements
- R1: The A register loads `a_i` on every rising edge of `clk_ab_i`, whatever the values of `en_ni` and `dir_i`.
- R2: The B register loads `b_i` on every rising edge of `clk_ba_i`, whatever the values of `en_ni` and `dir_i`. A `clk_ab_i` edge leaves the B register unchanged.
- R3: While `en_ni` is 1 (isolation), `a_oe_o` and `b_oe_o` are both 8'h00 and `a_o` and `b_o` are both 8'h00.
- R4: With `en_ni`=0 and `dir_i`=1, `b_oe_o`=8'hFF and `a_oe_o`=8'h00. With `en_ni`=0 and `dir_i`=0, `a_oe_o`=8'hFF and `b_oe_o`=8'h00. The two enables are never nonzero at the same time.
- R5: When B is driven and `sel_ab_i`=0, `b_o` equals the live `a_i` in the same cycle.
- R6: When B is driven and `sel_ab_i`=1, `b_o` equals the A register.
- R7: When A is driven, `a_o` equals the live `b_i` if `sel_ba_i`=0 and the B register if `sel_ba_i`=1.
- R8: In stored mode, a value captured by a clock edge appears on the driven port right after that edge, with no extra stage.
- R9: With `INVERT`=1, each driven output is the bitwise complement of its selected source, on both the live and the stored path. The registers still hold the true values.
- R10: `rst_ni`=0 clears both registers to 8'h00 at once, without a clock edge.
- R11: The output vector of a port that is not driven reads 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab_i | input | 1 | Capture clock of the A register |
| clk_ba_i | input | 1 | Capture clock of the B register |
| rst_ni | input | 1 | Asynchronous active-low clear of both registers |
| en_ni | input | 1 | Active-low output enable; 1 isolates both ports |
| dir_i | input | 1 | 1: A to B (B driven), 0: B to A (A driven) |
| sel_ab_i | input | 1 | Source for B: 0 live A, 1 stored A |
| sel_ba_i | input | 1 | Source for A: 0 live B, 1 stored B |
| a_i | input | 8 | A bus pad input |
| a_o | output | 8 | A bus pad output value |
| a_oe_o | output | 8 | A bus pad output enable, one bit per line |
| b_i | input | 8 | B bus pad input |
| b_o | output | 8 | B bus pad output value |
| b_oe_o | output | 8 | B bus pad output enable, one bit per line |

## Verification
The control inputs are swept over both isolation settings, both directions and both source selections. The live buses and the register contents are kept to different values, so every source choice gives a different output. Live and stored values use complementary nibbles (3C, A5, F0, 0F), which tells a wrong source apart from an inverted one, and an inverting copy of the block runs on the same stimulus to check the polarity option. Captures are made while both ports are isolated, to show that storing does not depend on the enable. A capture in stored mode confirms that the new value appears on the driven port right after the edge. An asynchronous reset applied without any clock confirms the immediate clear.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int unsigned BUS_W = 8;

  typedef enum logic [1:0] {
    PATH_IDLE = 2'd0,
    PATH_A2B  = 2'd1,
    PATH_B2A  = 2'd2
  } path_e;
endpackage

// File: rtl/xcvr_ctrl.sv
module xcvr_ctrl
  import xcvr_pkg::*;
(
  input  logic  en_ni,
  input  logic  dir_i,
  output path_e path_o
);
  always_comb begin
    if (en_ni)      path_o = PATH_IDLE;
    else if (dir_i) path_o = PATH_A2B;
    else            path_o = PATH_B2A;
  end
endmodule

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/xcvr_out_mux.sv
module xcvr_out_mux #(
  parameter int unsigned W      = 8,
  parameter bit          INVERT = 1'b0
) (
  input  logic         active_i,
  input  logic         sel_i,
  input  logic [W-1:0] live_i,
  input  logic [W-1:0] stored_i,
  output logic [W-1:0] data_o,
  output logic [W-1:0] oe_o
);
  logic [W-1:0] src;
  logic [W-1:0] pol;

  assign src = sel_i ? stored_i : live_i;

  generate
    if (INVERT) begin : g_inv
      assign pol = ~src;
    end else begin : g_true
      assign pol = src;
    end
  endgenerate

  // undriven port parks at zero
  assign data_o = active_i ? pol : '0;
  assign oe_o   = {W{active_i}};
endmodule

// File: rtl/xcvr_reg_bus.sv
module xcvr_reg_bus
  import xcvr_pkg::*;
#(
  parameter int unsigned W      = BUS_W,
  parameter bit          INVERT = 1'b0
) (
  input  logic         clk_ab_i,
  input  logic         clk_ba_i,
  input  logic         rst_ni,
  input  logic         en_ni,
  input  logic         dir_i,
  input  logic         sel_ab_i,
  input  logic         sel_ba_i,
  input  logic [W-1:0] a_i,
  output logic [W-1:0] a_o,
  output logic [W-1:0] a_oe_o,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] b_o,
  output logic [W-1:0] b_oe_o
);
  path_e        path;
  logic [W-1:0] a_q;
  logic [W-1:0] b_q;
  logic         drive_a;
  logic         drive_b;

  xcvr_ctrl u_ctrl (
    .en_ni  (en_ni),
    .dir_i  (dir_i),
    .path_o (path)
  );

  assign drive_b = (path == PATH_A2B);
  assign drive_a = (path == PATH_B2A);

  xcvr_store #(.W(W)) u_reg_a (
    .clk_i  (clk_ab_i),
    .rst_ni (rst_ni),
    .d_i    (a_i),
    .q_o    (a_q)
  );

  xcvr_store #(.W(W)) u_reg_b (
    .clk_i  (clk_ba_i),
    .rst_ni (rst_ni),
    .d_i    (b_i),
    .q_o    (b_q)
  );

  xcvr_out_mux #(.W(W), .INVERT(INVERT)) u_mux_b (
    .active_i (drive_b),
    .sel_i    (sel_ab_i),
    .live_i   (a_i),
    .stored_i (a_q),
    .data_o   (b_o),
    .oe_o     (b_oe_o)
  );

  xcvr_out_mux #(.W(W), .INVERT(INVERT)) u_mux_a (
    .active_i (drive_a),
    .sel_i    (sel_ba_i),
    .live_i   (b_i),
    .stored_i (b_q),
    .data_o   (a_o),
    .oe_o     (a_oe_o)
  );
endmodule

// File: rtl/xcvr_reg_bus_chk.sv
module xcvr_reg_bus_chk #(
  parameter int unsigned W      = 8,
  parameter bit          INVERT = 1'b0
) (
  input logic         clk_ab_i,
  input logic         clk_ba_i,
  input logic         rst_ni,
  input logic         en_ni,
  input logic         dir_i,
  input logic         sel_ab_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [W-1:0] a_o,
  input logic [W-1:0] b_o,
  input logic [W-1:0] a_oe_o,
  input logic [W-1:0] b_oe_o,
  input logic [W-1:0] a_q,
  input logic [W-1:0] b_q
);
  localparam logic [W-1:0] MASK = INVERT ? '1 : '0;

  AST_A_CAPTURE: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    1'b1 |=> a_q == $past(a_i)); // R1
  AST_B_CAPTURE: assert property (@(posedge clk_ba_i) disable iff (!rst_ni)
    1'b1 |=> b_q == $past(b_i)); // R2
  AST_ISOLATE: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    en_ni |-> (a_oe_o == '0 && b_oe_o == '0 && a_o == '0 && b_o == '0)); // R3
  AST_OE_EXCL: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    !((|a_oe_o) && (|b_oe_o))); // R4
  AST_OE_FULL_B: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    (!en_ni && dir_i) |-> b_oe_o == '1); // R4
  AST_LIVE_B: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    (!en_ni && dir_i && !sel_ab_i) |-> b_o == (a_i ^ MASK)); // R5
  AST_STORED_B: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    (!en_ni && dir_i && sel_ab_i) |-> b_o == (a_q ^ MASK)); // R6
  AST_UNDRIVEN_A: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    (a_oe_o == '0) |-> a_o == '0); // R11
endmodule

bind xcvr_reg_bus xcvr_reg_bus_chk #(.W(W), .INVERT(INVERT)) u_chk (
  .clk_ab_i (clk_ab_i),
  .clk_ba_i (clk_ba_i),
  .rst_ni   (rst_ni),
  .en_ni    (en_ni),
  .dir_i    (dir_i),
  .sel_ab_i (sel_ab_i),
  .a_i      (a_i),
  .b_i      (b_i),
  .a_o      (a_o),
  .b_o      (b_o),
  .a_oe_o   (a_oe_o),
  .b_oe_o   (b_oe_o),
  .a_q      (a_q),
  .b_q      (b_q)
);

// File: tb/xcvr_reg_bus_bench.sv
`timescale 1ns/1ps
module xcvr_reg_bus_bench;
  logic       clk = 1'b0;
  logic       gate_ab = 1'b0, gate_ba = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_ni = 1'b1, dir_i = 1'b0, sel_ab_i = 1'b0, sel_ba_i = 1'b0;
  logic [7:0] a_i = '0, b_i = '0;
  logic [7:0] a_o, a_oe_o, b_o, b_oe_o;
  logic [7:0] ia_o, ia_oe_o, ib_o, ib_oe_o;
  logic       clk_ab, clk_ba;
  int         n_checks = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;
  assign clk_ab = clk & gate_ab;
  assign clk_ba = clk & gate_ba;

  xcvr_reg_bus u_xcvr_reg_bus (
    .clk_ab_i(clk_ab), .clk_ba_i(clk_ba), .rst_ni(rst_ni), .en_ni(en_ni),
    .dir_i(dir_i), .sel_ab_i(sel_ab_i), .sel_ba_i(sel_ba_i),
    .a_i(a_i), .a_o(a_o), .a_oe_o(a_oe_o), .b_i(b_i), .b_o(b_o), .b_oe_o(b_oe_o));

  xcvr_reg_bus #(.INVERT(1'b1)) u_xcvr_reg_bus_inv (
    .clk_ab_i(clk_ab), .clk_ba_i(clk_ba), .rst_ni(rst_ni), .en_ni(en_ni),
    .dir_i(dir_i), .sel_ab_i(sel_ab_i), .sel_ba_i(sel_ba_i),
    .a_i(a_i), .a_o(ia_o), .a_oe_o(ia_oe_o), .b_i(b_i), .b_o(ib_o), .b_oe_o(ib_oe_o));

  // {en,dir,sab,sba, a[8], b[8], exp_a_o[8], exp_a_oe, exp_b_o[8], exp_b_oe}
  // registers hold A=3C, B=A5 while the table runs
  localparam int NV = 8;
  localparam logic [37:0] VEC [NV] = '{
    {4'b1100, 8'h11, 8'h22, 8'h00, 1'b0, 8'h00, 1'b0},
    {4'b1011, 8'h11, 8'h22, 8'h00, 1'b0, 8'h00, 1'b0},
    {4'b0100, 8'h11, 8'h22, 8'h00, 1'b0, 8'h11, 1'b1},
    {4'b0110, 8'h11, 8'h22, 8'h00, 1'b0, 8'h3C, 1'b1},
    {4'b0000, 8'h11, 8'h22, 8'h22, 1'b1, 8'h00, 1'b0},
    {4'b0001, 8'h11, 8'h22, 8'hA5, 1'b1, 8'h00, 1'b0},
    {4'b0101, 8'hF0, 8'h0F, 8'h00, 1'b0, 8'hF0, 1'b1},
    {4'b0010, 8'hF0, 8'h0F, 8'h0F, 1'b1, 8'h00, 1'b0}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_ab();
    @(negedge clk); gate_ab = 1'b1;
    @(negedge clk); gate_ab = 1'b0;
    #1;
  endtask

  task automatic pulse_ba();
    @(negedge clk); gate_ba = 1'b1;
    @(negedge clk); gate_ba = 1'b0;
    #1;
  endtask

  task automatic set_ctl(input logic en, input logic dir, input logic sab, input logic sba);
    en_ni = en; dir_i = dir; sel_ab_i = sab; sel_ba_i = sba;
    #1;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: registers cleared while reset held
    set_ctl(1'b0, 1'b1, 1'b1, 1'b0);
    chk("R10 A reg after reset", b_o, 8'h00);
    chk("R9 inverted stored zero", ib_o, 8'hFF);
    set_ctl(1'b0, 1'b0, 1'b0, 1'b1);
    chk("R10 B reg after reset", a_o, 8'h00);
    rst_ni = 1'b1;
    #1;

    // R1/R2: capture while isolated
    set_ctl(1'b1, 1'b1, 1'b1, 1'b1);
    a_i = 8'h3C; b_i = 8'h77;
    pulse_ab();
    chk("R3 isolated b_o", b_o, 8'h00);
    b_i = 8'hA5; a_i = 8'h00;
    pulse_ba();
    set_ctl(1'b0, 1'b1, 1'b1, 1'b0);
    chk("R1 A reg loaded under isolation", b_o, 8'h3C);
    chk("R9 A reg stored true", ib_o, 8'hC3);
    set_ctl(1'b0, 1'b0, 1'b0, 1'b1);
    chk("R2 B reg loaded under isolation", a_o, 8'hA5);

    for (int i = 0; i < NV; i++) begin
      logic [37:0] v;
      string ta, tb;
      v = VEC[i];
      a_i = v[33:26]; b_i = v[25:18];
      set_ctl(v[37], v[36], v[35], v[34]);
      if (v[37]) begin ta = "R3"; tb = "R3"; end
      else if (v[36]) begin ta = "R11"; tb = v[35] ? "R6" : "R5"; end
      else begin ta = "R7"; tb = "R11"; end
      chk({ta, " a_o"}, a_o, v[17:10]);
      chk({tb, " b_o"}, b_o, v[8:1]);
      chk({v[37] ? "R3" : "R4", " a_oe"}, a_oe_o, {8{v[9]}});
      chk({v[37] ? "R3" : "R4", " b_oe"}, b_oe_o, {8{v[0]}});
      chk("R9 inverted a_o", ia_o, v[9] ? ~v[17:10] : 8'h00);
      chk("R9 inverted b_o", ib_o, v[0] ? ~v[8:1] : 8'h00);
    end

    // R8: stored-mode capture shows at once; R2: B reg untouched by clk_ab
    set_ctl(1'b0, 1'b1, 1'b1, 1'b0);
    a_i = 8'h5A;
    chk("R6 before capture", b_o, 8'h3C);
    pulse_ab();
    chk("R8 new A value on B", b_o, 8'h5A);
    chk("R8 inverted", ib_o, 8'hA5);
    set_ctl(1'b0, 1'b0, 1'b0, 1'b1);
    chk("R2 B reg kept across clk_ab", a_o, 8'hA5);
    b_i = 8'hC3;
    pulse_ba();
    chk("R8 new B value on A", a_o, 8'hC3);

    // R10: asynchronous clear, no clock
    rst_ni = 1'b0;
    #1;
    chk("R10 async clear B reg", a_o, 8'h00);
    set_ctl(1'b0, 1'b1, 1'b1, 1'b0);
    chk("R10 async clear A reg", b_o, 8'h00);
    rst_ni = 1'b1;
    #1;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule